// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital side of a 16-bit sampling converter. The analog core is replaced by a parallel sample input. A falling edge on the active-low start input begins a conversion. `busy` then stays high for a fixed, parameterised number of clock cycles. On the edge where `busy` drops, the sample input is captured into a result register.

An acquisition phase of its own parameterised length always follows a conversion. If the start input is still low when that phase ends, the next conversion begins on its own, so holding start low gives free-running conversions. A level-sensitive power-down input blocks new conversions, but it never cuts one short.

The result is read through a parallel output that a pad driver turns into a tri-state bus. The output drives only while both the select and the read strobe are low. A coding input chooses straight binary or two's complement as the result is presented.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A falling edge of `start_n` seen while idle makes `busy` high from the next clock edge, and `busy` stays high for exactly CONV_CYCLES cycles.
- R2: A conversion in progress cannot be restarted or aborted. Edges on `start_n` and any level of `pwr_dn` while `busy` is high leave its length unchanged.
- R3: Activity on `cs_n` and `rd_n` has no effect on a conversion's start or length.
- R4: After each conversion, `busy` stays low for at least ACQ_CYCLES cycles. If `start_n` is low and `pwr_dn` is low when that acquisition ends, the next conversion starts at once, so `busy` is low for exactly ACQ_CYCLES cycles between free-running conversions.
- R5: While `pwr_dn` is high and no conversion runs, no conversion starts. If `pwr_dn` is high when an acquisition ends, free-running stops. Releasing `pwr_dn` with `start_n` held low starts a conversion on the next edge.
- R6: The result register takes `sample_in` on the clock edge where `busy` falls, and it does not change while `busy` is high.
- R7: After reset, no conversion starts until `start_n` has made a high-to-low transition. A `start_n` held low through and after reset starts nothing.
- R8: With `coding_twos` = 0, `bus_out` shows the result as straight binary. With `coding_twos` = 1, it shows the result with bit 15 inverted (two's complement). The select acts on the output at once, without a new conversion.
- R9: `bus_en` is 1 only when `cs_n` and `rd_n` are both 0. Otherwise `bus_en` is 0 and `bus_out` is all zeros.
- R10: If `start_n` is high when an acquisition ends, the block goes idle, and `busy` stays low until `start_n` falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Convert start, active low, edge and level sensitive |
| pwr_dn | input | 1 | Power-down request, level sensitive |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| coding_twos | input | 1 | 1 = two's complement output, 0 = straight binary |
| sample_in | input | DATA_W | Digitised value standing in for the analog core |
| busy | output | 1 | High while a conversion runs |
| bus_en | output | 1 | Drive enable for the tri-state data pads |
| bus_out | output | DATA_W | Result as presented to the pads (zero when not enabled) |

## Verification
The bench builds the block with CONV_CYCLES = 6 and ACQ_CYCLES = 3 and keeps the 16-bit width. These short phases let one run cover many things: single conversions, a run of free-running conversions with the acquisition gap measured, disturbances in the middle of a conversion, and power-down both while idle and across a conversion boundary. They also make every busy and idle interval short enough to count cycle by cycle. The full width keeps the MSB-inversion corner cases, 0x8000 and 0xFFFF, within reach.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/start_arm.sv
module start_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic fall,
    output logic armed
);
    typedef struct packed {
        logic prev;
        logic armed;
    } arm_t;

    arm_t s_d, s_q;

    assign fall  = s_q.prev & ~start_n;
    assign armed = s_q.armed;

    always_comb begin
        s_d       = s_q;
        s_d.prev  = start_n;
        s_d.armed = s_q.armed | fall;
    end

    // The level before reset release counts as low, so a start held low gives no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    arm_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> armed);

endmodule

// File: rtl/out_format.sv
module out_format #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic              coding_twos,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              bus_en,
    output logic [DATA_W-1:0] bus_out
);
    logic [DATA_W-1:0] coded_d;

    always_comb begin
        coded_d = result;
        if (coding_twos) begin
            coded_d[DATA_W-1] = ~result[DATA_W-1];
        end
        bus_en  = ~(cs_n | rd_n);
        bus_out = bus_en ? coded_d : '0;
    end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20,
    parameter int ACQ_CYCLES  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              pwr_dn,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              coding_twos,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic              bus_en,
    output logic [DATA_W-1:0] bus_out
);
    localparam int CNT_MAX = max_u(CONV_CYCLES, ACQ_CYCLES);
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] result;
    } seq_t;

    seq_t s_d, s_q;
    logic fall;
    logic armed;
    logic start_ok;

    start_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_n (start_n),
        .fall    (fall),
        .armed   (armed)
    );

    always_comb begin
        s_d      = s_q;
        start_ok = ~pwr_dn & ~start_n & (armed | fall);
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_ok) begin
                    s_d.phase = PH_CONV;
                    s_d.cnt   = CONV_LAST;
                end
            end
            PH_CONV: begin
                if (s_q.cnt == '0) begin
                    s_d.phase  = PH_ACQ;
                    s_d.cnt    = ACQ_LAST;
                    s_d.result = sample_in;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_ACQ: begin
                if (s_q.cnt == '0) begin
                    if (start_ok) begin
                        s_d.phase = PH_CONV;
                        s_d.cnt   = CONV_LAST;
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, result: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.phase == PH_CONV);

    out_format #(.DATA_W(DATA_W)) u_fmt (
        .result      (s_q.result),
        .coding_twos (coding_twos),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .bus_en      (bus_en),
        .bus_out     (bus_out)
    );

    // Checker state: length of the current busy run
    int unsigned run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R1 R2
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CONV_CYCLES));

    // R5
    idle_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && s_q.phase == PH_IDLE && pwr_dn) |=> !busy);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(s_q.result));

    // R7
    armed_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> armed);

    // R4
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ACQ && s_q.cnt == '0 && !start_n && !pwr_dn) |=> busy);

    // R9
    bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!bus_en && bus_out == '0));

endmodule

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_conv_ctrl;
    localparam int DW   = 16;
    localparam int CONV = 6;
    localparam int ACQ  = 3;

    logic clk = 1'b0;
    logic rst_n, start_n, pwr_dn, cs_n, rd_n, coding_twos;
    logic [DW-1:0] sample_in;
    logic busy, bus_en;
    logic [DW-1:0] bus_out;

    always #10 clk = ~clk;

    adc_conv_ctrl #(.DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_dn(pwr_dn),
        .cs_n(cs_n), .rd_n(rd_n), .coding_twos(coding_twos),
        .sample_in(sample_in), .busy(busy), .bus_en(bus_en), .bus_out(bus_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_q[$];
    int rises   = 0;
    int hi_cnt  = 0;
    int lo_cnt  = 0;
    int last_gap = 0;
    logic busy_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fmt(input logic [DW-1:0] v, input logic twos);
        return twos ? {~v[DW-1], v[DW-2:0]} : v;
    endfunction

    // Monitor: a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (busy) begin
                if (!busy_prev) begin
                    rises++;
                    last_gap = lo_cnt;
                    lo_cnt = 0;
                end
                hi_cnt++;
            end else begin
                if (busy_prev) begin
                    check(hi_cnt == CONV, "R1 busy length", hi_cnt, CONV);
                    hi_cnt = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected result", bus_out, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = fmt(exp_q.pop_front(), coding_twos);
                        check(bus_en && bus_out == e, "R6 result", bus_out, e);
                    end
                end
                lo_cnt++;
            end
            busy_prev = busy;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: one conversion, start released while busy so no free-run follows
    task automatic single(input logic [DW-1:0] v);
        sample_in = v;
        exp_q.push_back(v);
        @(negedge clk); start_n = 1'b0;
        @(negedge clk); #1;
        check(busy == 1'b1, "R1 busy after edge", busy, 1);
        start_n = 1'b1;
        cyc(CONV + ACQ + 2);
        #1;
        check(busy == 1'b0, "R10 idle with start high", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int r0;
        rst_n = 1'b0; start_n = 1'b0; pwr_dn = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        coding_twos = 1'b0; sample_in = '0;
        cyc(3); #1;
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(bus_en == 1'b0 && bus_out == '0, "R9 reset bus off", bus_out, 0);
        rst_n = 1'b1;

        // R7: start held low since reset, no edge, nothing starts
        cyc(15); #1;
        check(busy == 1'b0 && rises == 0, "R7 no start without edge", rises, 0);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); start_n = 1'b1;

        single(16'h1234);
        single(16'hFFFF);
        single(16'h0000);

        // R8: coding select on the output
        coding_twos = 1'b1;
        single(16'h1234);
        check(bus_out == 16'h9234, "R8 twos of 1234", bus_out, 16'h9234);
        coding_twos = 1'b0; #1;
        check(bus_out == 16'h1234, "R8 straight live switch", bus_out, 16'h1234);
        coding_twos = 1'b1;
        single(16'h8000);
        check(bus_out == 16'h0000, "R8 twos of 8000", bus_out, 0);
        coding_twos = 1'b0;

        // R9: select and read gate the bus
        @(negedge clk); cs_n = 1'b1; #1;
        check(!bus_en && bus_out == '0, "R9 cs high", bus_out, 0);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check(!bus_en && bus_out == '0, "R9 rd high", bus_out, 0);
        rd_n = 1'b0; #1;
        check(bus_en && bus_out == 16'h8000, "R9 both low", bus_out, 16'h8000);

        // R2 R3: disturbances in mid-conversion
        r0 = rises;
        sample_in = 16'h0F0F; exp_q.push_back(16'h0F0F);
        @(negedge clk); start_n = 1'b0;
        @(negedge clk); start_n = 1'b1;
        @(negedge clk); start_n = 1'b0; pwr_dn = 1'b1; cs_n = 1'b1;
        @(negedge clk); start_n = 1'b1; pwr_dn = 1'b0; rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        cyc(CONV + ACQ + 2); #1;
        check(rises == r0 + 1, "R2 no restart", rises, r0 + 1);
        check(busy == 1'b0, "R3 conversion ended", busy, 0);

        // R4: free-running conversions
        r0 = rises;
        sample_in = 16'hA001; exp_q.push_back(16'hA001);
        @(negedge clk); start_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            while (!busy) @(negedge clk);
            if (k > 0) check(last_gap == ACQ, "R4 acquisition gap", last_gap, ACQ);
            while (busy) @(negedge clk);
            if (k < 2) begin
                sample_in = 16'hA002 + 16'(k);
                exp_q.push_back(16'hA002 + 16'(k));
            end
        end
        start_n = 1'b1;
        cyc(ACQ + 4); #1;
        check(rises == r0 + 3 && !busy, "R10 free-run stops", rises, r0 + 3);

        // R5: power-down while idle, then across a conversion boundary
        r0 = rises;
        pwr_dn = 1'b1;
        @(negedge clk); start_n = 1'b0;
        cyc(10); #1;
        check(rises == r0 && !busy, "R5 blocked while power-down", rises, r0);
        sample_in = 16'h5A5A; exp_q.push_back(16'h5A5A);
        pwr_dn = 1'b0;
        @(negedge clk); #1;
        check(busy == 1'b1, "R5 release starts", busy, 1);
        pwr_dn = 1'b1;
        cyc(CONV + ACQ + 4); #1;
        check(rises == r0 + 1 && !busy, "R5 no restart after power-down", rises, r0 + 1);
        pwr_dn = 1'b0; start_n = 1'b1;
        cyc(3);

        check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule